// File: doc/BRIEF.md
# Masked Data Watchpoint Comparator

This block observes the processor's data-side bus and flags accesses that fit programmed criteria. It holds a number of independent watchpoint units, two by default. Each unit stores a value and a mask for the access address, for the data word and for a small control vector. A set mask bit means the bit is ignored; a clear mask bit means the bus bit must equal the stored value.

The control vector describes the access: transfer direction, access width, privilege level and a per-unit external condition. It also holds a comparison-mode bit and an enable bit. Both of these always take part in the comparison, whatever their mask bits hold. Software or a debug path loads the registers through a one-cycle write port. Each unit drives a registered hit flag, and a combined flag is set when any unit hits.

Top module: `wp_data_watch`

## Requirements
- R1: After reset every stored register is zero, so every unit is disabled, and `wp_match` and `wp_any` read 0 even while valid bus traffic is present.
- R2: A write with `cfg_we`=1 loads `cfg_wdata` into the register that `cfg_field` picks in the unit that `cfg_unit` picks. The field codes are: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value, 5 control mask. Codes 6 and 7 change no register.
- R3: Address and data are compared bit by bit. A mask bit of 1 drops that bit from the comparison. A mask bit of 0 requires the bus bit to equal the stored bit.
- R4: Control value encoding: bit 0 is direction (0 read, 1 write), bits 2:1 are access size, bit 4 is privilege (0 user, 1 privileged) and bit 5 is the external condition. Each of these is compared under its mask bit. Bits 6 and 7 are never compared.
- R5: Control bit 3 selects data comparison and must be 1 for a unit to hit. Setting control mask bit 3 has no effect.
- R6: Control bit 8 enables the unit and must be 1 for a unit to hit. Setting control mask bit 8 has no effect.
- R7: Unit i compares its external-condition bit with input `ext_cond[i]` only.
- R8: `wp_match[i]` is registered. It rises one clock after a bus cycle with `bus_valid`=1 that fits unit i. It is 0 after any cycle with `bus_valid`=0.
- R9: `wp_any` is the OR of all `wp_match` bits in the same cycle.
- R10: Each unit is programmed and compared independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_unit | input | UNIT_W | Target unit of the write |
| cfg_field | input | 3 | Target register code |
| cfg_wdata | input | REG_W | Write data |
| bus_valid | input | 1 | Data-access valid strobe |
| bus_addr | input | ADDR_W | Data-access address |
| bus_data | input | DATA_W | Data-access data word |
| bus_write | input | 1 | Direction, 1 for a write |
| bus_size | input | 2 | Access size code |
| bus_priv | input | 1 | 1 for a privileged access |
| ext_cond | input | NUM_WP | External conditions, one per unit |
| wp_match | output | NUM_WP | Registered hit flag per unit |
| wp_any | output | 1 | Registered OR of all hit flags |

## Verification
The bench builds the block with its defaults: two units and 32-bit address and data buses. With two units it can drive both external-condition inputs in all four combinations and observe each unit's flag independently. The 32-bit width lets it place mask patterns in the upper and lower halves of the address and the data word. The two locked control bits are exercised with a control mask of all ones, where only those bits still decide the outcome.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int CTL_W     = 9;
    localparam int CTL_DIR   = 0;
    localparam int CTL_SZ_LO = 1;
    localparam int CTL_MODE  = 3;
    localparam int CTL_PRIV  = 4;
    localparam int CTL_EXT   = 5;
    localparam int CTL_EN    = 8;

    // bits never compared (reserved) and bits whose mask is never honoured
    localparam logic [CTL_W-1:0] CTL_IGNORED = 9'h0C0;
    localparam logic [CTL_W-1:0] CTL_LOCKED  = (9'h1 << CTL_MODE) | (9'h1 << CTL_EN);

    typedef enum logic [2:0] {
        FLD_ADDR_VAL = 3'd0,
        FLD_ADDR_MSK = 3'd1,
        FLD_DATA_VAL = 3'd2,
        FLD_DATA_MSK = 3'd3,
        FLD_CTRL_VAL = 3'd4,
        FLD_CTRL_MSK = 3'd5
    } wp_field_e;
endpackage

// File: rtl/wp_masked_cmp.sv
module wp_masked_cmp #(
    parameter int W = 32,
    parameter logic [W-1:0] FORCE_IGNORE = '0,
    parameter logic [W-1:0] NEVER_MASK   = '0
) (
    input  logic [W-1:0] ref_val,
    input  logic [W-1:0] ref_msk,
    input  logic [W-1:0] observed,
    output logic         hit
);
    logic [W-1:0] eff_msk;
    logic [W-1:0] diff;

    always_comb begin
        eff_msk = (ref_msk & ~NEVER_MASK) | FORCE_IGNORE;
        diff    = (ref_val ^ observed) & ~eff_msk;
        hit     = (diff == '0);
    end
endmodule

// File: rtl/wp_unit.sv
module wp_unit
    import wp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  wp_field_e         wr_field,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] obs_addr,
    input  logic [DATA_W-1:0] obs_data,
    input  logic [CTL_W-1:0]  obs_ctl,
    output logic              hit,
    output logic              enabled,
    output logic              data_mode
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr_val;
        logic [ADDR_W-1:0] addr_msk;
        logic [DATA_W-1:0] data_val;
        logic [DATA_W-1:0] data_msk;
        logic [CTL_W-1:0]  ctl_val;
        logic [CTL_W-1:0]  ctl_msk;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_field)
                FLD_ADDR_VAL: regs_d.addr_val = wr_data[ADDR_W-1:0];
                FLD_ADDR_MSK: regs_d.addr_msk = wr_data[ADDR_W-1:0];
                FLD_DATA_VAL: regs_d.data_val = wr_data[DATA_W-1:0];
                FLD_DATA_MSK: regs_d.data_msk = wr_data[DATA_W-1:0];
                FLD_CTRL_VAL: regs_d.ctl_val  = wr_data[CTL_W-1:0];
                FLD_CTRL_MSK: regs_d.ctl_msk  = wr_data[CTL_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    logic addr_hit, data_hit, ctl_hit;

    wp_masked_cmp #(.W(ADDR_W)) u_addr_cmp (
        .ref_val(regs_q.addr_val), .ref_msk(regs_q.addr_msk),
        .observed(obs_addr), .hit(addr_hit)
    );

    wp_masked_cmp #(.W(DATA_W)) u_data_cmp (
        .ref_val(regs_q.data_val), .ref_msk(regs_q.data_msk),
        .observed(obs_data), .hit(data_hit)
    );

    wp_masked_cmp #(
        .W(CTL_W), .FORCE_IGNORE(CTL_IGNORED), .NEVER_MASK(CTL_LOCKED)
    ) u_ctl_cmp (
        .ref_val(regs_q.ctl_val), .ref_msk(regs_q.ctl_msk),
        .observed(obs_ctl), .hit(ctl_hit)
    );

    assign hit       = addr_hit & data_hit & ctl_hit;
    assign enabled   = regs_q.ctl_val[CTL_EN];
    assign data_mode = regs_q.ctl_val[CTL_MODE];
endmodule

// File: rtl/wp_data_watch.sv
module wp_data_watch
    import wp_pkg::*;
#(
    parameter int NUM_WP = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int UNIT_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1,
    localparam int REG_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [UNIT_W-1:0] cfg_unit,
    input  logic [2:0]        cfg_field,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic              bus_priv,
    input  logic [NUM_WP-1:0] ext_cond,
    output logic [NUM_WP-1:0] wp_match,
    output logic              wp_any
);
    typedef struct packed {
        logic [NUM_WP-1:0] match;
        logic              any;
    } out_t;

    out_t out_d, out_q;

    logic [NUM_WP-1:0] unit_hit;
    logic [NUM_WP-1:0] unit_en;
    logic [NUM_WP-1:0] unit_mode;

    for (genvar i = 0; i < NUM_WP; i++) begin : g_unit
        logic [CTL_W-1:0] obs_ctl;
        logic             wr_sel;

        always_comb begin
            obs_ctl                 = '0;
            obs_ctl[CTL_DIR]        = bus_write;
            obs_ctl[CTL_SZ_LO+:2]   = bus_size;
            obs_ctl[CTL_MODE]       = 1'b1;
            obs_ctl[CTL_PRIV]       = bus_priv;
            obs_ctl[CTL_EXT]        = ext_cond[i];
            obs_ctl[CTL_EN]         = 1'b1;
            wr_sel = cfg_we && (cfg_unit == UNIT_W'(i));
        end

        wp_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_sel),
            .wr_field (wp_field_e'(cfg_field)),
            .wr_data  (cfg_wdata),
            .obs_addr (bus_addr),
            .obs_data (bus_data),
            .obs_ctl  (obs_ctl),
            .hit      (unit_hit[i]),
            .enabled  (unit_en[i]),
            .data_mode(unit_mode[i])
        );
    end

    always_comb begin
        out_d.match = bus_valid ? unit_hit : '0;
        out_d.any   = |out_d.match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign wp_match = out_q.match;
    assign wp_any   = out_q.any;
endmodule

// File: rtl/wp_data_watch_chk.sv
module wp_data_watch_chk #(
    parameter int NUM_WP = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic [NUM_WP-1:0] wp_match,
    input logic              wp_any,
    input logic [NUM_WP-1:0] unit_en,
    input logic [NUM_WP-1:0] unit_mode
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (wp_match == '0 && !wp_any));

    // R9
    any_is_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp_any == (|wp_match));

    for (genvar i = 0; i < NUM_WP; i++) begin : g_chk
        // R8
        match_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wp_match[i] |-> $past(bus_valid));
        // R6
        match_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wp_match[i] |-> $past(unit_en[i]));
        // R5
        match_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wp_match[i] |-> $past(unit_mode[i]));
    end
endmodule

bind wp_data_watch wp_data_watch_chk #(.NUM_WP(NUM_WP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .wp_match (wp_match),
    .wp_any   (wp_any),
    .unit_en  (unit_en),
    .unit_mode(unit_mode)
);

// File: tb/wp_data_watch_tb.sv
module wp_data_watch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_unit = '0;
    logic [2:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = '0;
    logic        bus_priv = 1'b0;
    logic [1:0]  ext_cond = '0;
    logic [1:0]  wp_match;
    logic        wp_any;

    int checks = 0;
    int fails  = 0;

    localparam logic [31:0] A0 = 32'h1000_0040;
    localparam logic [31:0] D0 = 32'hDEAD_BEEF;
    // enable(8) | mode(3) | priv(4) | size=2 (2:1) | write(0)
    localparam logic [31:0] CV = 32'h11D;

    always #2 clk = ~clk;

    wp_data_watch u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_unit(cfg_unit),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_write(bus_write),
        .bus_size(bus_size), .bus_priv(bus_priv), .ext_cond(ext_cond),
        .wp_match(wp_match), .wp_any(wp_any)
    );

    task automatic expect_m(input string tag, input logic [1:0] exp);
        checks++;
        if (wp_match !== exp) begin
            fails++;
            $display("FAIL %s match: got %b expected %b", tag, wp_match, exp);
        end
        checks++;
        if (wp_any !== (|exp)) begin
            fails++;
            $display("FAIL %s/R9 any: got %b expected %b", tag, wp_any, |exp);
        end
    endtask

    task automatic wr(input logic u, input logic [2:0] f, input logic [31:0] d);
        cfg_we = 1'b1; cfg_unit = u; cfg_field = f; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic prog(input logic u, input logic [31:0] av, am, dv, dm, cv, cm);
        bus_valid = 1'b0;
        wr(u, 3'd0, av); wr(u, 3'd1, am); wr(u, 3'd2, dv);
        wr(u, 3'd3, dm); wr(u, 3'd4, cv); wr(u, 3'd5, cm);
    endtask

    task automatic cyc(input logic v, input logic [31:0] a, d, input logic rw,
                       input logic [1:0] sz, input logic pv, input logic [1:0] e);
        bus_valid = v; bus_addr = a; bus_data = d; bus_write = rw;
        bus_size = sz; bus_priv = pv; ext_cond = e;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        expect_m("R1 reset", 2'b00);
        cyc(1, 32'h0, 32'h0, 0, 2'd0, 0, 2'b00);
        expect_m("R1 zero traffic while disabled", 2'b00);
        cyc(1, A0, D0, 1, 2'd2, 1, 2'b11);
        expect_m("R1 traffic while disabled", 2'b00);
    endtask

    task automatic t_basic();
        prog(0, A0, 0, D0, 0, CV, 0);
        cyc(0, A0, D0, 1, 2'd2, 1, 2'b00);
        expect_m("R8 idle cycle", 2'b00);
        bus_valid = 1'b1; #1;
        expect_m("R8 not before edge", 2'b00);
        @(posedge clk); #1;
        expect_m("R3 R8 exact hit", 2'b01);
        cyc(0, A0, D0, 1, 2'd2, 1, 2'b00);
        expect_m("R8 valid low", 2'b00);
        cyc(1, A0 ^ 32'h10, D0, 1, 2'd2, 1, 2'b00);
        expect_m("R3 address bit differs", 2'b00);
        cyc(1, A0, D0 ^ 32'h8000_0000, 1, 2'd2, 1, 2'b00);
        expect_m("R3 data bit differs", 2'b00);
    endtask

    task automatic t_mask();
        wr(0, 3'd1, 32'h0000_00FF);
        wr(0, 3'd3, 32'hFFFF_0000);
        cyc(1, 32'h1000_00AB, 32'h1234_BEEF, 1, 2'd2, 1, 2'b00);
        expect_m("R3 masked bits ignored", 2'b01);
        cyc(1, 32'h1100_0040, D0, 1, 2'd2, 1, 2'b00);
        expect_m("R3 unmasked addr bit", 2'b00);
        cyc(1, A0, 32'hDEAD_BEE0, 1, 2'd2, 1, 2'b00);
        expect_m("R3 unmasked data bit", 2'b00);
        wr(0, 3'd1, 0);
        wr(0, 3'd3, 0);
    endtask

    task automatic t_ctl();
        cyc(1, A0, D0, 0, 2'd2, 1, 2'b00);
        expect_m("R4 direction read vs write", 2'b00);
        cyc(1, A0, D0, 1, 2'd1, 1, 2'b00);
        expect_m("R4 size mismatch", 2'b00);
        cyc(1, A0, D0, 1, 2'd2, 0, 2'b00);
        expect_m("R4 user vs privileged", 2'b00);
        cyc(1, A0, D0, 1, 2'd2, 1, 2'b01);
        expect_m("R4 external condition", 2'b00);
        wr(0, 3'd5, 32'h3F);
        cyc(1, A0, D0, 0, 2'd1, 0, 2'b01);
        expect_m("R4 fields masked", 2'b01);
        wr(0, 3'd5, 0);
        wr(0, 3'd4, CV | 32'hC0);
        cyc(1, A0, D0, 1, 2'd2, 1, 2'b00);
        expect_m("R4 bits 6 and 7 ignored", 2'b01);
        wr(0, 3'd4, CV & ~32'h8);
        wr(0, 3'd5, 32'h1FF);
        cyc(1, A0, D0, 0, 2'd3, 0, 2'b11);
        expect_m("R5 mode clear with mask set", 2'b00);
        wr(0, 3'd4, CV);
        cyc(1, A0, D0, 0, 2'd3, 0, 2'b11);
        expect_m("R5 mode set, rest masked", 2'b01);
        wr(0, 3'd4, CV & ~32'h100);
        cyc(1, A0, D0, 1, 2'd2, 1, 2'b00);
        expect_m("R6 enable clear with mask set", 2'b00);
        wr(0, 3'd4, CV);
        wr(0, 3'd5, 0);
    endtask

    task automatic t_ext();
        prog(0, A0, 0, D0, 0, CV | 32'h20, 0);
        prog(1, A0, 0, D0, 0, CV, 0);
        cyc(1, A0, D0, 1, 2'd2, 1, 2'b01);
        expect_m("R7 R10 ext 01", 2'b11);
        cyc(1, A0, D0, 1, 2'd2, 1, 2'b10);
        expect_m("R7 R10 ext 10", 2'b00);
        cyc(1, A0, D0, 1, 2'd2, 1, 2'b11);
        expect_m("R7 R10 ext 11", 2'b01);
        cyc(1, A0, D0, 1, 2'd2, 1, 2'b00);
        expect_m("R7 R10 ext 00", 2'b10);
    endtask

    task automatic t_bad_field();
        bus_valid = 1'b0;
        wr(0, 3'd6, 32'hFFFF_FFFF);
        wr(0, 3'd7, 32'h0000_0000);
        cyc(1, A0, D0, 1, 2'd2, 1, 2'b01);
        expect_m("R2 codes 6 and 7 change nothing", 2'b11);
        wr(1, 3'd0, 32'h2000_0000);
        cyc(1, A0, D0, 1, 2'd2, 1, 2'b01);
        expect_m("R2 R10 write reaches selected unit only", 2'b01);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_basic();
        t_mask();
        t_ctl();
        t_ext();
        t_bad_field();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule